// File: doc/BRIEF.md
# Packed BCD add/subtract unit

This unit takes two 8-bit operands, each holding two packed decimal digits, and a carry input. It either adds them with carry or subtracts them with borrow, as chosen per operation by a mode input. Each operation presented with `in_valid` is registered once. One clock later the unit gives the packed decimal result and four flags: negative, overflow, zero and carry.

In add mode the flags follow the legacy decimal-mode rules. Zero, negative and overflow are taken from intermediate digit sums before the decimal correction is complete, so they can disagree with the final result. In subtract mode a borrow passes from the low digit to the high digit. Negative and zero come from the final result, and overflow uses the binary signed rule. Digits above 9 give a defined result that follows the same arithmetic; no error is raised.

Top module: `bcd_addsub_unit`

## Requirements
- R1: During and right after reset, `out_valid`, `result` and all four flags are 0.
- R2: Add mode (`sub_mode`=0). Let lo = A[3:0]+B[3:0]+cin and hi = A[7:4]+B[7:4]. When lo > 9, add 6 to lo and 1 to hi. Then, when hi > 9, add 6 to hi. `result` = {hi[3:0], lo[3:0]}. For valid decimal operands every result digit is at most 9.
- R3: Add mode: `flag_c` is 1 exactly when the final hi is greater than 15.
- R4: Add mode: `flag_z` is 1 exactly when bits [7:0] of (lo + hi) are zero. Here lo and hi are the raw digit sums, taken before any correction.
- R5: Add mode: `flag_n` is bit 3 of hi after the low-digit carry has been added and before the high-digit correction.
- R6: Add mode: `flag_v` = ~(A[7]^B[7]) & (A[7]^h3), where h3 is the same bit used for R5.
- R7: Subtract mode (`sub_mode`=1). Let lo = A[3:0]−B[3:0]−1+cin. When lo < 0, add 10 to lo and borrow 1 from the high digit. hi = A[7:4]−B[7:4]−borrow; when hi < 0, add 10 to it. `result` = {hi[3:0], lo[3:0]}, with negative values taken as two's complement.
- R8: Subtract mode: `flag_c` is 0 when hi was negative before its correction, and 1 otherwise.
- R9: Subtract mode: `flag_n` is `result[7]` and `flag_z` is (`result`==0).
- R10: Subtract mode: `flag_v` = (A[7]^B[7]) & (A[7]^result[7]).
- R11: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1. When `in_valid` is 0, the result and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| sub_mode | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| opa | input | 8 | First packed decimal operand |
| opb | input | 8 | Second packed decimal operand |
| carry_in | input | 1 | Carry in (in subtract mode, 0 means borrow) |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | 8 | Packed decimal result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry out |

## Verification
The result and all four flags are due exactly one rising edge after the operation is presented, together with `out_valid`. The bench changes inputs on the falling edge and keeps one expected value pending. At the next falling edge it compares the outputs with that value before it drives the next operation. This lets an operation go in every cycle, and each comparison falls on the cycle in which its operation's registers have loaded.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  parameter int DIG_W  = 4;
  localparam int BYTE_W = 2 * DIG_W;
  localparam int SUM_W  = DIG_W + 2;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              n;
    logic              v;
    logic              z;
    logic              c;
  } bcd_res_t;

  // Decimal add: legacy flag quirks taken from partial sums.
  function automatic bcd_res_t bcd_add_f(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] b,
                                         input logic              cin);
    logic [SUM_W-1:0]  lo;
    logic [SUM_W-1:0]  hi;
    logic [BYTE_W-1:0] raw;
    bcd_res_t          r;
    lo  = SUM_W'(a[DIG_W-1:0]) + SUM_W'(b[DIG_W-1:0]) + SUM_W'(cin);
    hi  = SUM_W'(a[BYTE_W-1:DIG_W]) + SUM_W'(b[BYTE_W-1:DIG_W]);
    raw = BYTE_W'(lo) + BYTE_W'(hi);
    r.z = (raw == '0);
    if (lo > SUM_W'(9)) begin
      lo = lo + SUM_W'(6);
      hi = hi + SUM_W'(1);
    end
    r.n = hi[DIG_W-1];
    r.v = ~(a[BYTE_W-1] ^ b[BYTE_W-1]) & (a[BYTE_W-1] ^ hi[DIG_W-1]);
    if (hi > SUM_W'(9)) hi = hi + SUM_W'(6);
    r.c   = (hi > SUM_W'(15));
    r.res = {hi[DIG_W-1:0], lo[DIG_W-1:0]};
    return r;
  endfunction

  // Decimal subtract with digit borrow; flags from final result.
  function automatic bcd_res_t bcd_sub_f(input logic [BYTE_W-1:0] a,
                                         input logic [BYTE_W-1:0] b,
                                         input logic              cin);
    logic signed [SUM_W-1:0] lo;
    logic signed [SUM_W-1:0] hi;
    logic                    brw;
    bcd_res_t                r;
    lo  = $signed(SUM_W'(a[DIG_W-1:0])) - $signed(SUM_W'(b[DIG_W-1:0]))
          - $signed(SUM_W'(1)) + $signed(SUM_W'(cin));
    brw = lo[SUM_W-1];
    if (brw) lo = lo + $signed(SUM_W'(10));
    hi  = $signed(SUM_W'(a[BYTE_W-1:DIG_W])) - $signed(SUM_W'(b[BYTE_W-1:DIG_W]))
          - $signed(SUM_W'(brw));
    r.c = ~hi[SUM_W-1];
    if (hi[SUM_W-1]) hi = hi + $signed(SUM_W'(10));
    r.res = {hi[DIG_W-1:0], lo[DIG_W-1:0]};
    r.n   = r.res[BYTE_W-1];
    r.z   = (r.res == '0);
    r.v   = (a[BYTE_W-1] ^ b[BYTE_W-1]) & (a[BYTE_W-1] ^ r.res[BYTE_W-1]);
    return r;
  endfunction
endpackage

// File: rtl/bcd_add_core.sv
module bcd_add_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output bcd_res_t          out,
  output logic              lo_fix
);
  assign out    = bcd_add_f(a, b, cin);
  assign lo_fix = (SUM_W'(a[DIG_W-1:0]) + SUM_W'(b[DIG_W-1:0]) + SUM_W'(cin)) > SUM_W'(9);
endmodule

// File: rtl/bcd_sub_core.sv
module bcd_sub_core
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output bcd_res_t          out,
  output logic              lo_borrow
);
  assign out       = bcd_sub_f(a, b, cin);
  assign lo_borrow = ({1'b0, a[DIG_W-1:0]} + {{DIG_W{1'b0}}, cin})
                     < ({1'b0, b[DIG_W-1:0]} + {{DIG_W{1'b0}}, 1'b1});
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage
  import bcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     load_sub,
  input  bcd_res_t d,
  output bcd_res_t q,
  output logic     q_valid,
  output logic     q_sub
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
      q_sub   <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q     <= d;
        q_sub <= load_sub;
      end
    end
  end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              sub_mode,
  input  logic [BYTE_W-1:0] opa,
  input  logic [BYTE_W-1:0] opb,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] result,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c
);
  bcd_res_t add_res;
  bcd_res_t sub_res;
  bcd_res_t sel_res;
  bcd_res_t held;
  logic     add_lo_fix;
  logic     sub_lo_borrow;
  logic     held_sub;

  bcd_add_core u_add (.a(opa), .b(opb), .cin(carry_in), .out(add_res), .lo_fix(add_lo_fix));
  bcd_sub_core u_sub (.a(opa), .b(opb), .cin(carry_in), .out(sub_res), .lo_borrow(sub_lo_borrow));

  assign sel_res = sub_mode ? sub_res : add_res;

  bcd_out_stage u_stage (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .load_sub(sub_mode),
    .d(sel_res), .q(held), .q_valid(out_valid), .q_sub(held_sub)
  );

  assign result = held.res;
  assign flag_n = held.n;
  assign flag_v = held.v;
  assign flag_z = held.z;
  assign flag_c = held.c;
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       sub_mode,
  input logic [7:0] opa,
  input logic [7:0] opb,
  input logic       out_valid,
  input logic [7:0] result,
  input logic       flag_n,
  input logic       flag_v,
  input logic       flag_z,
  input logic       flag_c,
  input logic       held_sub,
  input logic       add_lo_fix
);
  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)));

  p_sub_nz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && held_sub) |-> (flag_n == result[7] && flag_z == (result == 8'd0)));

  p_sub_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_mode) |=>
      (flag_v == (($past(opa[7]) ^ $past(opb[7])) & ($past(opa[7]) ^ result[7]))));

  p_add_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_mode && opa[3:0] < 4'd10 && opa[7:4] < 4'd10
     && opb[3:0] < 4'd10 && opb[7:4] < 4'd10)
      |=> (result[3:0] < 4'd10 && result[7:4] < 4'd10));

  p_add_fix_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_mode && add_lo_fix && opa[3:0] < 4'd10 && opb[3:0] < 4'd10)
      |=> (result[3:0] <= 4'd9));
endmodule

bind bcd_addsub_unit bcd_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_mode(sub_mode),
  .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
  .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
  .held_sub(held_sub), .add_lo_fix(add_lo_fix)
);

// File: tb/test_bcd_addsub_unit.sv
module test_bcd_addsub_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       sub_mode = 1'b0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] result;
  logic       flag_n, flag_v, flag_z, flag_c;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  bit  pend = 0;
  bit  pend_sub;
  int  exp_res, exp_n, exp_v, exp_z, exp_c;

  always #5 clk = ~clk;

  bcd_addsub_unit i_bcd_addsub_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_mode(sub_mode),
    .opa(opa), .opb(opb), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
  );

  // Model in whole integers, following the requirements.
  task automatic model(input bit s, input int a, input int b, input int c);
    int al = a % 16, ah = a / 16, bl = b % 16, bh = b / 16;
    int lo, hi, brw;
    if (!s) begin
      lo = al + bl + c;
      hi = ah + bh;
      exp_z = (((lo + hi) % 256) == 0);              // R4
      if (lo >= 10) begin lo += 6; hi += 1; end
      exp_n = (hi / 8) % 2;                          // R5
      exp_v = ((a / 128) == (b / 128)) && ((a / 128) != exp_n); // R6
      if (hi >= 10) hi += 6;
      exp_c = (hi >= 16);                            // R3
      exp_res = (hi % 16) * 16 + (lo % 16);          // R2
    end else begin
      lo = al - bl - 1 + c;
      brw = (lo < 0);
      if (brw) lo += 10;
      hi = ah - bh - brw;
      exp_c = (hi >= 0);                             // R8
      if (hi < 0) hi += 10;
      exp_res = ((hi & 15) << 4) | (lo & 15);        // R7
      exp_n = exp_res / 128;                         // R9
      exp_z = (exp_res == 0);
      exp_v = ((a / 128) != (b / 128)) && ((a / 128) != exp_n); // R10
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      string rq_res = pend_sub ? "R7" : "R2";
      chk(out_valid == 1'b1, "R11 out_valid", out_valid, 1);
      chk(result == exp_res[7:0], rq_res, result, exp_res);
      chk(flag_c == exp_c[0], pend_sub ? "R8" : "R3", flag_c, exp_c);
      chk(flag_z == exp_z[0], pend_sub ? "R9 z" : "R4", flag_z, exp_z);
      chk(flag_n == exp_n[0], pend_sub ? "R9 n" : "R5", flag_n, exp_n);
      chk(flag_v == exp_v[0], pend_sub ? "R10" : "R6", flag_v, exp_v);
      pend = 0;
    end
  endtask

  // At each falling edge: compare the previous operation, then present a new one.
  task automatic apply(input bit s, input int a, input int b, input int c);
    @(negedge clk);
    check_pending();
    in_valid = 1'b1; sub_mode = s; opa = a[7:0]; opb = b[7:0]; carry_in = c[0];
    model(s, a, b, c);
    pend = 1; pend_sub = s;
  endtask

  task automatic go_idle();
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int dummy;
    logic [7:0] keep_res;
    dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(result == 8'h00, "R1 result", result, 0);
    chk({flag_n, flag_v, flag_z, flag_c} == 4'b0, "R1 flags", {flag_n, flag_v, flag_z, flag_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 after release", out_valid, 0);

    // Directed corners
    apply(0, 'h99, 'h01, 0);   // R3 carry out, result 00
    apply(0, 'h00, 'h00, 0);   // R4 z from raw sums
    apply(0, 'h79, 'h00, 1);   // R5/R6 n and v from partial high digit
    apply(0, 'h50, 'h50, 0);   // R3 high adjust
    apply(1, 'h00, 'h01, 1);   // R7/R8 full borrow -> 99, c=0
    apply(1, 'h10, 'h01, 1);   // R7 low borrow -> 09
    apply(1, 'h42, 'h42, 1);   // R9 zero result
    apply(1, 'h80, 'h01, 1);   // R10 sign change
    go_idle();

    // R11: idle inputs leave outputs untouched
    keep_res = result;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 idle valid", out_valid, 0);
    opa = 8'h55; opb = 8'h44; sub_mode = 1'b0;
    @(negedge clk);
    chk(result == keep_res, "R11 hold", result, keep_res);

    // Exhaustive add mode (R2-R6)
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(0, a, b, c);

    // Valid decimal operands in subtract mode (R7-R10)
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 100; a++)
        for (int b = 0; b < 100; b++)
          apply(1, (a / 10) * 16 + a % 10, (b / 10) * 16 + b % 10, c);

    // Random mix including invalid digits
    for (int i = 0; i < 1000; i++)
      apply($urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 1));
    go_idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule